// File: doc/BRIEF.md
# Indirect Register Access Bridge for a Two-Wire Serial Controller

This block lets a host reach a small bank of 8-bit registers inside a two-wire serial controller through one 64-bit command word. The host writes a word that carries a start flag, an operation class, a register selector, a direction flag and a data byte. The bridge holds the word, spends a fixed number of clock cycles on the internal access, and then clears the start flag. On a read, the selected byte replaces bits [7:0] of the same word. Software polls the start flag to learn when the access has retired.

A second 64-bit word, at byte offset 0x10, holds an enable for the status interrupt and two line-override bits. The serial engine itself is not built. It is represented by the register bank, whose contents are brought out as ports, and by a status-load input through which the engine posts a new status byte.

The host side is a plain single-cycle register port: a write is taken on any edge where `csr_we` is high, and `csr_rdata` follows `csr_addr` combinationally. There is no back-pressure; a command write that arrives while an access is in flight is dropped.

Top module: `twi_csr_bridge`

## Requirements
- R1: A write to offset 0x00 with bit 63 set, while no access is pending, starts an access. Bit 63 reads 1 from the next cycle and reads 0 exactly LAT cycles (default 3) after the accepting edge.
- R2: A write to offset 0x00 while bit 63 still reads 1 is dropped. The stored word and the access outcome are those of the first command.
- R3: Bits 59:58 = 11 select an extended access, with the selector in bits [34:32]. With bit 56 set (read), bits [7:0] return data (sel 1), control (sel 2) or status (sel 3), and 0 for any other selector.
- R4: An extended write (bit 56 clear) loads the byte in bits [7:0] into data (sel 1), control (sel 2) or clock control (sel 3). The written byte stays in bits [7:0].
- R5: Bits 59:58 = 10 address the 8-bit clock high-period register. A write loads it, and a read returns it in bits [7:0].
- R6: An extended write to selector 7 sets the status register to 0xF8 (idle).
- R7: Command-word bits other than 63, 59:58, 56, 34:32 and 7:0 always read 0. A command write with bit 63 clear changes nothing.
- R8: When bit 59 is clear, the access retires with no register change, and a read returns 0 in bits [7:0].
- R9: Offset 0x10 stores bit 6 (interrupt enable), bit 9 (force clock line low) and bit 8 (force data line low). It reads back only those bits. `irq` is high exactly when the enable is set and status is not 0xF8.
- R10: `eng_stat_we` loads `eng_stat` into status on the next edge. If a selector-7 write retires on that same edge, the reset wins and status becomes 0xF8.
- R11: A status read that retires on the same edge as an engine status load returns the old status. The new value is visible afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Host write strobe |
| csr_addr | input | 5 | Host byte offset (0x00 command, 0x10 interrupt) |
| csr_wdata | input | 64 | Host write data |
| csr_rdata | output | 64 | Host read data for csr_addr |
| eng_stat_we | input | 1 | Engine posts a new status byte |
| eng_stat | input | 8 | Status byte from the engine |
| irq | output | 1 | Status interrupt |
| scl_force_low | output | 1 | Clock line override |
| sda_force_low | output | 1 | Data line override |
| ctl_q | output | 8 | Control register |
| data_q | output | 8 | Data register |
| clkctl_q | output | 8 | Clock-control register |
| clkhi_q | output | 8 | Clock high-period register |

## Verification
Two events can meet on one clock edge: an engine status load, and a retiring access that touches status (a selector-7 reset or a status read). The bench times `eng_stat_we` so that it lands exactly on the retire edge, which it finds by counting LAT cycles from the accepting edge. For a reset, status must read 0xF8 afterwards and `irq` must stay low. For a read, the returned byte must be the pre-edge status, and a follow-up read must show the new value.

// File: rtl/twi_bridge_pkg.sv
package twi_bridge_pkg;
  localparam int WORD_W   = 64;
  localparam int BYTE_W   = 8;
  localparam int POS_GO   = 63;
  localparam int POS_OPHI = 59;
  localparam int POS_OPLO = 58;
  localparam int POS_RD   = 56;
  localparam int POS_SELH = 34;
  localparam int POS_SELL = 32;
  localparam int POS_IEN  = 6;
  localparam int POS_SDAF = 8;
  localparam int POS_SCLF = 9;

  localparam logic [1:0] OP_EXT   = 2'b11;
  localparam logic [1:0] OP_CLKHI = 2'b10;
  localparam logic [2:0] SEL_DATA = 3'd1;
  localparam logic [2:0] SEL_CTL  = 3'd2;
  localparam logic [2:0] SEL_CLK  = 3'd3;
  localparam logic [2:0] SEL_RST  = 3'd7;
  localparam logic [7:0] STAT_IDLE = 8'hF8;

  typedef struct packed {
    logic       rd;
    logic [1:0] op;
    logic [2:0] sel;
    logic [7:0] val;
  } cmd_t;
endpackage

// File: rtl/twi_cmd_timer.sv
module twi_cmd_timer #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(LAT + 1) + 1;
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(LAT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      busy <= start;
      cnt  <= '0;
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r1_retire_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r1_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank
  import twi_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  cmd_t       cmd,
  input  logic       eng_stat_we,
  input  logic [7:0] eng_stat,
  output logic [7:0] rd_byte,
  output logic [7:0] ctl_q,
  output logic [7:0] data_q,
  output logic [7:0] clkctl_q,
  output logic [7:0] clkhi_q,
  output logic [7:0] stat_q
);
  logic ext_wr, hi_wr, soft_rst;

  assign ext_wr   = fire && !cmd.rd && (cmd.op == OP_EXT);
  assign hi_wr    = fire && !cmd.rd && (cmd.op == OP_CLKHI);
  assign soft_rst = ext_wr && (cmd.sel == SEL_RST);

  always_comb begin
    rd_byte = '0;
    if (cmd.op == OP_CLKHI) rd_byte = clkhi_q;
    else if (cmd.op == OP_EXT) begin
      case (cmd.sel)
        SEL_DATA: rd_byte = data_q;
        SEL_CTL:  rd_byte = ctl_q;
        SEL_CLK:  rd_byte = stat_q;
        default:  rd_byte = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      data_q   <= '0;
      clkctl_q <= '0;
      clkhi_q  <= '0;
      stat_q   <= STAT_IDLE;
    end else begin
      if (ext_wr && cmd.sel == SEL_DATA) data_q   <= cmd.val;
      if (ext_wr && cmd.sel == SEL_CTL)  ctl_q    <= cmd.val;
      if (ext_wr && cmd.sel == SEL_CLK)  clkctl_q <= cmd.val;
      if (hi_wr)                         clkhi_q  <= cmd.val;
      if (soft_rst)                      stat_q   <= STAT_IDLE;
      else if (eng_stat_we)              stat_q   <= eng_stat;
    end
  end

  a_r6_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> stat_q == STAT_IDLE);
  a_r10_engine_load: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_stat_we && !soft_rst) |=> stat_q == $past(eng_stat));
  a_r8_no_touch: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cmd.op[1]) |=> ($stable(ctl_q) && $stable(data_q) && $stable(clkctl_q) && $stable(clkhi_q)));
endmodule

// File: rtl/twi_csr_bridge.sv
module twi_csr_bridge
  import twi_bridge_pkg::*;
#(
  parameter int LAT = 3,
  parameter int AW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_we,
  input  logic [AW-1:0] csr_addr,
  input  logic [63:0]   csr_wdata,
  output logic [63:0]   csr_rdata,
  input  logic          eng_stat_we,
  input  logic [7:0]    eng_stat,
  output logic          irq,
  output logic          scl_force_low,
  output logic          sda_force_low,
  output logic [7:0]    ctl_q,
  output logic [7:0]    data_q,
  output logic [7:0]    clkctl_q,
  output logic [7:0]    clkhi_q
);
  localparam logic [AW-1:0] OFF_CMD = AW'(0);
  localparam logic [AW-1:0] OFF_INT = AW'(16);

  cmd_t       cmd_q, cmd_in;
  logic       busy, done, start, int_en;
  logic [7:0] rd_byte, stat_q;

  assign cmd_in = '{rd:  csr_wdata[POS_RD],
                    op:  csr_wdata[POS_OPHI:POS_OPLO],
                    sel: csr_wdata[POS_SELH:POS_SELL],
                    val: csr_wdata[7:0]};
  assign start = csr_we && (csr_addr == OFF_CMD) && csr_wdata[POS_GO] && !busy;

  twi_cmd_timer #(.LAT(LAT)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done));

  twi_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .fire(done), .cmd(cmd_q),
    .eng_stat_we(eng_stat_we), .eng_stat(eng_stat), .rd_byte(rd_byte),
    .ctl_q(ctl_q), .data_q(data_q), .clkctl_q(clkctl_q),
    .clkhi_q(clkhi_q), .stat_q(stat_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q         <= '0;
      int_en        <= 1'b0;
      scl_force_low <= 1'b0;
      sda_force_low <= 1'b0;
    end else begin
      if (start) cmd_q <= cmd_in;
      else if (done && cmd_q.rd) cmd_q.val <= rd_byte;
      if (csr_we && csr_addr == OFF_INT) begin
        int_en        <= csr_wdata[POS_IEN];
        scl_force_low <= csr_wdata[POS_SCLF];
        sda_force_low <= csr_wdata[POS_SDAF];
      end
    end
  end

  assign irq = int_en && (stat_q != STAT_IDLE);

  always_comb begin
    csr_rdata = '0;
    if (csr_addr == OFF_CMD) begin
      csr_rdata[POS_GO]            = busy;
      csr_rdata[POS_OPHI:POS_OPLO] = cmd_q.op;
      csr_rdata[POS_RD]            = cmd_q.rd;
      csr_rdata[POS_SELH:POS_SELL] = cmd_q.sel;
      csr_rdata[7:0]               = cmd_q.val;
    end else if (csr_addr == OFF_INT) begin
      csr_rdata[POS_IEN]  = int_en;
      csr_rdata[POS_SCLF] = scl_force_low;
      csr_rdata[POS_SDAF] = sda_force_low;
    end
  end

  a_r2_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(cmd_q));
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> int_en);
  a_r1_start_sets_go: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: tb/sim_twi_csr_bridge.sv
module sim_twi_csr_bridge;
  localparam int LAT = 3;
  logic clk = 0, rst_n = 0, csr_we = 0, eng_stat_we = 0;
  logic [4:0] csr_addr = 0;
  logic [63:0] csr_wdata = 0, csr_rdata;
  logic [7:0] eng_stat = 0, ctl_q, data_q, clkctl_q, clkhi_q;
  logic irq, scl_force_low, sda_force_low;
  int n_run = 0, n_fail = 0;
  logic [7:0] m_ctl = 0, m_data = 0, m_clk = 0, m_hi = 0, m_stat = 8'hF8;
  logic m_en = 0;

  always #2 clk = ~clk;

  twi_csr_bridge #(.LAT(LAT)) u0 (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pack(input logic rd, input logic [1:0] op,
                                       input logic [2:0] sel, input logic [7:0] b);
    logic [63:0] w = '0;
    w[59:58] = op; w[56] = rd; w[34:32] = sel; w[7:0] = b;
    return w;
  endfunction

  function automatic logic [7:0] model_cmd(input logic rd, input logic [1:0] op,
                                           input logic [2:0] sel, input logic [7:0] b);
    if (rd) begin
      if (op == 2'b10) return m_hi;
      if (op == 2'b11) case (sel)
        3'd1: return m_data; 3'd2: return m_ctl; 3'd3: return m_stat;
        default: return 8'h00;
      endcase
      return 8'h00;
    end
    if (op == 2'b10) m_hi = b;
    if (op == 2'b11) case (sel)
      3'd1: m_data = b; 3'd2: m_ctl = b; 3'd3: m_clk = b; 3'd7: m_stat = 8'hF8;
      default: ;
    endcase
    return b;
  endfunction

  task automatic host_wr(input logic [4:0] a, input logic [63:0] w);
    @(negedge clk); csr_we = 1; csr_addr = a; csr_wdata = w;
    @(negedge clk); csr_we = 0; csr_addr = 0;
  endtask

  task automatic wait_retire(output int n);
    n = 0;
    while (csr_rdata[63] && n < 50) begin @(negedge clk); n++; end
  endtask

  task automatic run_cmd(input logic rd, input logic [1:0] op, input logic [2:0] sel,
                         input logic [7:0] b, input logic [63:0] junk);
    int n; logic [7:0] r;
    host_wr(0, pack(rd, op, sel, b) | junk | 64'h8000_0000_0000_0000);
    check("R1 go set", csr_rdata[63], 1'b1);
    wait_retire(n);
    check("R1 latency", n, LAT);
    r = model_cmd(rd, op, sel, b);
    check(op[1] ? (op[0] ? "R3/R4 ext word" : "R5 clkhi word") : "R8 undefined op word",
          csr_rdata, pack(rd, op, sel, r));
  endtask

  task automatic check_bank();
    check("R4 ctl", ctl_q, m_ctl);
    check("R4 data", data_q, m_data);
    check("R4 clkctl", clkctl_q, m_clk);
    check("R5 clkhi", clkhi_q, m_hi);
    check("R9 irq", irq, m_en && (m_stat != 8'hF8));
  endtask

  task automatic eng_post(input logic [7:0] s);
    @(negedge clk); eng_stat_we = 1; eng_stat = s;
    @(negedge clk); eng_stat_we = 0; m_stat = s;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n; logic [63:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R7 reset cmd word", csr_rdata, 64'h0);
    check_bank();
    run_cmd(1, 2'b11, 3'd3, 8'h00, 0);                 // R3 idle status
    run_cmd(0, 2'b11, 3'd1, 8'hA5, 64'h0621_00FF_8000_FF00 & ~64'h8D00_0007_0000_00FF); // R7 junk dropped
    check_bank();
    // R7: write with go clear changes nothing
    w = csr_rdata;
    host_wr(0, pack(0, 2'b11, 3'd2, 8'h77));
    check("R7 go clear ignored", csr_rdata, w);
    check("R7 ctl untouched", ctl_q, m_ctl);
    // R2: write during busy dropped
    host_wr(0, 64'h8000_0000_0000_0000 | pack(0, 2'b11, 3'd2, 8'h3C));
    @(negedge clk); csr_we = 1; csr_wdata = 64'h8000_0000_0000_0000 | pack(0, 2'b10, 3'd0, 8'hEE);
    @(negedge clk); csr_we = 0;
    check("R2 stored word kept", csr_rdata, 64'h8000_0000_0000_0000 | pack(0, 2'b11, 3'd2, 8'h3C));
    wait_retire(n);
    void'(model_cmd(0, 2'b11, 3'd2, 8'h3C));
    check("R2 outcome of first", csr_rdata, pack(0, 2'b11, 3'd2, 8'h3C));
    check_bank();
    // R9 interrupt CSR
    host_wr(16, 64'hFFFF_FFFF_FFFF_FFFF); m_en = 1;
    csr_addr = 16; #0;
    @(negedge clk);
    check("R9 int readback", csr_rdata, 64'h340);
    check("R9 overrides", {scl_force_low, sda_force_low}, 2'b11);
    csr_addr = 0;
    eng_post(8'h08);
    check_bank();
    // R10: soft reset and engine load on the same edge
    host_wr(0, 64'h8000_0000_0000_0000 | pack(0, 2'b11, 3'd7, 8'h00));
    repeat (LAT - 1) @(negedge clk);
    eng_stat_we = 1; eng_stat = 8'h28;
    @(negedge clk); eng_stat_we = 0;
    m_stat = 8'hF8;
    check("R10 reset wins", csr_rdata[63], 1'b0);
    check_bank();
    run_cmd(1, 2'b11, 3'd3, 8'h00, 0);
    // R11: status read retiring with an engine load
    host_wr(0, 64'h8000_0000_0000_0000 | pack(1, 2'b11, 3'd3, 8'h00));
    repeat (LAT - 1) @(negedge clk);
    eng_stat_we = 1; eng_stat = 8'h50;
    @(negedge clk); eng_stat_we = 0;
    check("R11 old status returned", csr_rdata[7:0], 8'hF8);
    m_stat = 8'h50;
    run_cmd(1, 2'b11, 3'd3, 8'h00, 0);
    check_bank();
    host_wr(16, 64'h0); m_en = 0;
    check("R9 overrides off", {scl_force_low, sda_force_low}, 2'b00);
    check_bank();
    // random mix
    for (int i = 0; i < 300; i++) begin
      int k = $urandom_range(0, 9);
      if (k == 0) eng_post(8'($urandom));
      else if (k == 1) begin
        logic en = 1'($urandom);
        host_wr(16, en ? 64'h40 : 64'h0); m_en = en;
      end else
        run_cmd(1'($urandom), 2'($urandom), 3'($urandom), 8'($urandom), 0);
      check_bank();
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule